// File: doc/BRIEF.md
# Serial EEPROM Burst Word Reader

This block fetches a run of 16-bit words from a serial EEPROM on a four-wire SPI bus on behalf of a host. The host pulses a request together with a starting word offset and a word count. The block checks that the range fits inside the device. It then polls the device status register until the device reports that it is not busy. After that it sends one read command with a byte address and streams in the requested words. Each word is handed back on a one-cycle valid strobe, with its two bytes exchanged.

The block generates chip select and the serial clock from the system clock. The clock divider, the opcode and address lengths, the device size and the poll limit are parameters. Every request ends in a one-cycle completion pulse. Two error flags mark a rejected range and a poll timeout. Parts that use 8 address bits carry the ninth byte-address bit inside the opcode.

Top module: `spi_eeprom_burst_rd`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, and busy, done and word_valid are 0.
- R2: A request is rejected when req_count is 0, when req_offset is SIZE_WORDS or larger, or when req_count exceeds SIZE_WORDS minus req_offset. On rejection, done and err_bounds are 1 in the second cycle after the request cycle, and spi_cs_n never goes low.
- R3: Before each read, the block sends the 8-bit status opcode 0x05 and then clocks in an 8-bit status byte within one chip-select frame. Status bit 0 equal to 1 means the device is busy: the block ends the frame, waits a standby gap and polls again. Bit 0 equal to 0 lets the read proceed.
- R4: After POLL_MAX consecutive busy status reads, the block ends with done and err_timeout both 1. It sends no read command and produces no words.
- R5: The read opcode is 0x03. When ADDR_BITS is 8 and the offset is 128 or more, the opcode is 0x0B, so that opcode bit 3 carries byte-address bit 8.
- R6: After the opcode, the block shifts out the byte address, equal to twice the word offset, MSB first, using its low ADDR_BITS bits.
- R7: Each word is 16 bits clocked in MSB first. word_data equals {second byte received, first byte received}. There is one word_valid pulse per word, exactly req_count words, and they arrive in ascending address order.
- R8: spi_cs_n is high for at least 2*SCK_HALF clock cycles before every command frame. It stays low from the first opcode bit to the last data bit. spi_sck is low whenever spi_cs_n is high.
- R9: The bus uses SPI mode 0. spi_mosi changes only while spi_sck is low, and spi_miso is sampled at the rising edge.
- R10: done is a one-cycle pulse that coincides with the fall of busy. err_bounds and err_timeout are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start pulse, sampled while idle |
| req_offset | input | OFS_W | Starting word offset |
| req_count | input | OFS_W | Number of words to read |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_bounds | output | 1 | Range rejected, valid with done |
| err_timeout | output | 1 | Device never ready, valid with done |
| word_valid | output | 1 | word_data holds a new word |
| word_data | output | 16 | Byte-swapped word |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A rejected range is due on fixed timing: busy rises in the first cycle after the request cycle and done falls due in the second. The bench counts negative edges from the request and checks that exact cycle. Words, poll outcomes and completion depend on the divided serial clock. For these, the bench samples every negative clock edge after the request until done appears, and collects each word_valid pulse as it occurs. It compares the collected words, the number of status frames seen by its device model, the opcode and the shortest chip-select gap against values computed from the model's memory. A cycle bound on that wait counts as a failure.

// File: rtl/spirx_pkg.sv
package spirx_pkg;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_A8   = 8'h08;
  localparam int unsigned STAT_BITS = 8;
  localparam int unsigned WORD_BITS = 16;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PSTBY,
    S_STAT_OP,
    S_STAT_RD,
    S_RSTBY,
    S_RD_OP,
    S_RD_ADDR,
    S_RD_DATA,
    S_FIN
  } rd_state_e;
endpackage

// File: rtl/spirx_bounds.sv
module spirx_bounds #(
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned SIZE_WORDS = 256
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [OFS_W-1:0] count,
  output logic             ok
);
  localparam int unsigned W = OFS_W + 2;
  localparam logic [W-1:0] SIZE_V = W'(SIZE_WORDS);

  logic [W-1:0] ofs_w, cnt_w, room;

  always_comb begin
    ofs_w = W'(offset);
    cnt_w = W'(count);
    room  = SIZE_V - ofs_w;
    ok    = (ofs_w < SIZE_V) && (cnt_w != '0) && (cnt_w <= room);
  end
endmodule

// File: rtl/spirx_bitshift.sv
module spirx_bitshift #(
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned MAXB     = 16,
  localparam int unsigned CW      = $clog2(MAXB + 1),
  localparam int unsigned DW      = $clog2(SCK_HALF + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   nbits,
  input  logic [MAXB-1:0] tx,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            done,
  output logic [MAXB-1:0] rx
);
  logic            act_q, act_d;
  logic            sck_q, sck_d;
  logic [DW-1:0]   div_q, div_d;
  logic [CW-1:0]   left_q, left_d;
  logic [MAXB-1:0] txs_q, txs_d;
  logic [MAXB-1:0] rxs_q, rxs_d;
  logic            done_q, done_d;

  always_comb begin
    act_d  = act_q;
    sck_d  = sck_q;
    div_d  = div_q;
    left_d = left_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        sck_d  = 1'b0;
        div_d  = '0;
        left_d = nbits;
        txs_d  = tx;
        rxs_d  = '0;
      end
    end else if (div_q == DW'(SCK_HALF - 1)) begin
      div_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
        rxs_d = {rxs_q[MAXB-2:0], miso};
      end else begin
        sck_d  = 1'b0;
        left_d = left_q - 1'b1;
        txs_d  = txs_q << 1;
        if (left_q == CW'(1)) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      div_q  <= '0;
      left_q <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      div_q  <= div_d;
      left_q <= left_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      done_q <= done_d;
    end
  end

  assign sck  = sck_q;
  assign mosi = txs_q[MAXB-1];
  assign done = done_q;
  assign rx   = rxs_q;
endmodule

// File: rtl/spi_eeprom_burst_rd.sv
module spi_eeprom_burst_rd
  import spirx_pkg::*;
#(
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned SIZE_WORDS = 256,
  parameter int unsigned ADDR_BITS  = 8,
  parameter int unsigned OP_BITS    = 8,
  parameter int unsigned SCK_HALF   = 2,
  parameter int unsigned POLL_MAX   = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [OFS_W-1:0] req_count,
  output logic             busy,
  output logic             done,
  output logic             err_bounds,
  output logic             err_timeout,
  output logic             word_valid,
  output logic [15:0]      word_data,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int unsigned MAXB     = WORD_BITS;
  localparam int unsigned CW       = $clog2(MAXB + 1);
  localparam int unsigned STBY_CYC = 2 * SCK_HALF;
  localparam int unsigned TW       = $clog2(STBY_CYC + 1);
  localparam int unsigned PW       = $clog2(POLL_MAX + 1);

  rd_state_e        st_q, st_d;
  logic [TW-1:0]    tmr_q, tmr_d;
  logic [PW-1:0]    poll_q, poll_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [OFS_W-1:0] left_q, left_d;
  logic             eb_q, eb_d, et_q, et_d;
  logic             wv_q, wv_d;
  logic [15:0]      wd_q, wd_d;
  logic             done_q, done_d;
  logic             cs_n_q, cs_n_d;

  logic             req_ok;
  logic             eng_start, eng_done;
  logic [CW-1:0]    eng_nbits;
  logic [MAXB-1:0]  eng_tx, eng_rx;
  logic [7:0]       rd_opc;
  logic [OFS_W:0]   byte_addr;
  logic [MAXB-1:0]  addr_tx;
  logic             stby_end;

  spirx_bounds #(.OFS_W(OFS_W), .SIZE_WORDS(SIZE_WORDS)) u_bounds (
    .offset (req_offset),
    .count  (req_count),
    .ok     (req_ok)
  );

  spirx_bitshift #(.SCK_HALF(SCK_HALF), .MAXB(MAXB)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (eng_start),
    .nbits (eng_nbits),
    .tx    (eng_tx),
    .miso  (spi_miso),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .done  (eng_done),
    .rx    (eng_rx)
  );

  // Ninth byte-address bit rides in the opcode only on 8-bit-address parts
  generate
    if (ADDR_BITS == 8) begin : g_a8_fold
      assign rd_opc = (ofs_q[OFS_W-1:7] != '0) ? (OPC_READ | OPC_A8) : OPC_READ;
    end else begin : g_plain_opc
      assign rd_opc = OPC_READ;
    end
  endgenerate

  assign byte_addr = {ofs_q, 1'b0};
  assign addr_tx   = MAXB'(byte_addr[ADDR_BITS-1:0]) << (MAXB - ADDR_BITS);
  assign stby_end  = (tmr_q == TW'(STBY_CYC - 1));

  always_comb begin
    st_d      = st_q;
    poll_d    = poll_q;
    ofs_d     = ofs_q;
    left_d    = left_q;
    eb_d      = eb_q;
    et_d      = et_q;
    wv_d      = 1'b0;
    wd_d      = wd_q;
    done_d    = 1'b0;
    eng_start = 1'b0;
    eng_nbits = '0;
    eng_tx    = '0;
    tmr_d     = (st_q == S_PSTBY || st_q == S_RSTBY) ? tmr_q + 1'b1 : '0;
    case (st_q)
      S_IDLE: begin
        if (req) begin
          ofs_d  = req_offset;
          left_d = req_count;
          poll_d = '0;
          eb_d   = !req_ok;
          et_d   = 1'b0;
          st_d   = req_ok ? S_PSTBY : S_FIN;
        end
      end
      S_PSTBY: begin
        if (stby_end) begin
          st_d      = S_STAT_OP;
          eng_start = 1'b1;
          eng_nbits = CW'(OP_BITS);
          eng_tx    = MAXB'(OPC_RDSR) << (MAXB - OP_BITS);
        end
      end
      S_STAT_OP: begin
        if (eng_done) begin
          st_d      = S_STAT_RD;
          eng_start = 1'b1;
          eng_nbits = CW'(STAT_BITS);
        end
      end
      S_STAT_RD: begin
        if (eng_done) begin
          if (eng_rx[0]) begin
            if (poll_q == PW'(POLL_MAX - 1)) begin
              et_d = 1'b1;
              st_d = S_FIN;
            end else begin
              poll_d = poll_q + 1'b1;
              st_d   = S_PSTBY;
            end
          end else begin
            st_d = S_RSTBY;
          end
        end
      end
      S_RSTBY: begin
        if (stby_end) begin
          st_d      = S_RD_OP;
          eng_start = 1'b1;
          eng_nbits = CW'(OP_BITS);
          eng_tx    = MAXB'(rd_opc) << (MAXB - OP_BITS);
        end
      end
      S_RD_OP: begin
        if (eng_done) begin
          st_d      = S_RD_ADDR;
          eng_start = 1'b1;
          eng_nbits = CW'(ADDR_BITS);
          eng_tx    = addr_tx;
        end
      end
      S_RD_ADDR: begin
        if (eng_done) begin
          st_d      = S_RD_DATA;
          eng_start = 1'b1;
          eng_nbits = CW'(WORD_BITS);
        end
      end
      S_RD_DATA: begin
        if (eng_done) begin
          wv_d   = 1'b1;
          wd_d   = {eng_rx[7:0], eng_rx[15:8]};
          left_d = left_q - 1'b1;
          if (left_q == OFS_W'(1)) begin
            st_d = S_FIN;
          end else begin
            eng_start = 1'b1;
            eng_nbits = CW'(WORD_BITS);
          end
        end
      end
      S_FIN: begin
        st_d   = S_IDLE;
        done_d = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
    cs_n_d = !(st_d == S_STAT_OP || st_d == S_STAT_RD || st_d == S_RD_OP ||
               st_d == S_RD_ADDR || st_d == S_RD_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tmr_q  <= '0;
      poll_q <= '0;
      ofs_q  <= '0;
      left_q <= '0;
      eb_q   <= 1'b0;
      et_q   <= 1'b0;
      wv_q   <= 1'b0;
      wd_q   <= '0;
      done_q <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      poll_q <= poll_d;
      ofs_q  <= ofs_d;
      left_q <= left_d;
      eb_q   <= eb_d;
      et_q   <= et_d;
      wv_q   <= wv_d;
      wd_q   <= wd_d;
      done_q <= done_d;
      cs_n_q <= cs_n_d;
    end
  end

  assign busy        = (st_q != S_IDLE);
  assign done        = done_q;
  assign err_bounds  = done_q & eb_q;
  assign err_timeout = done_q & et_q;
  assign word_valid  = wv_q;
  assign word_data   = wd_q;
  assign spi_cs_n    = cs_n_q;
endmodule

// File: rtl/spirx_chk.sv
module spirx_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err_bounds,
  input logic err_timeout,
  input logic word_valid,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck) else $error("sck high while deselected"); // R8

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi)) else $error("mosi moved while sck high"); // R9

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_bounds, err_timeout})) else $error("both error flags"); // R10

  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))) else $error("done not at busy fall"); // R10

  AST_WORD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (busy && !$past(spi_cs_n))) else $error("word outside frame"); // R7

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_bounds) |-> ($past(spi_cs_n) && spi_cs_n)) else $error("bus used on reject"); // R2

  AST_TIMEOUT_NOWORD: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> !word_valid) else $error("word with timeout"); // R4
endmodule

bind spi_eeprom_burst_rd spirx_chk u_chk (.*);

// File: tb/tb_spi_eeprom_burst_rd.sv
`timescale 1ns/1ps
module tb_spi_eeprom_burst_rd;
  localparam int CLK_P    = 10;
  localparam int HALF     = 2;
  localparam int PMAX     = 16;
  localparam int SIZE     = 256;
  localparam int AB       = 8;

  logic clk, rst_n, req;
  logic [15:0] req_offset, req_count;
  logic busy, done, err_bounds, err_timeout, word_valid, spi_cs_n, spi_sck, spi_mosi;
  logic [15:0] word_data;
  logic spi_miso;

  spi_eeprom_burst_rd #(.OFS_W(16), .SIZE_WORDS(SIZE), .ADDR_BITS(AB), .OP_BITS(8),
                        .SCK_HALF(HALF), .POLL_MAX(PMAX)) dut (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [7:0] mem [512];

  // ---- device model ----
  int bcnt, stat_reads, rd_cmds, busy_left, cs_falls;
  logic [7:0] opc, last_op, stv;
  logic [7:0] ash;
  int ptr;
  realtime t_rise, min_gap;

  always @(negedge spi_cs_n or posedge spi_sck) begin
    if (!spi_sck) begin
      bcnt = 0;
      cs_falls++;
    end else if (!spi_cs_n) begin
      if (bcnt < 8) opc = {opc[6:0], spi_mosi};
      else if (bcnt < 8 + AB) ash = {ash[6:0], spi_mosi};
      bcnt++;
      if (bcnt == 8) begin
        if (opc == 8'h05) stat_reads++;
        else if ((opc & 8'hF7) == 8'h03) begin rd_cmds++; last_op = opc; end
      end
      if (bcnt == 8 + AB && (opc & 8'hF7) == 8'h03) ptr = {opc[3], ash};
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && bcnt >= 8) begin
      if (opc == 8'h05) begin
        stv = (busy_left > 0) ? 8'h01 : 8'h00;
        spi_miso = stv[7 - ((bcnt - 8) % 8)];
      end else if ((opc & 8'hF7) == 8'h03 && bcnt >= 8 + AB) begin
        int idx;
        idx = bcnt - (8 + AB);
        spi_miso = mem[(ptr + idx / 8) % 512][7 - idx % 8];
      end
    end
  end

  always @(posedge spi_cs_n) begin
    t_rise = $realtime;
    if (opc == 8'h05 && bcnt >= 16 && busy_left > 0) busy_left--;
  end

  always @(negedge spi_cs_n) begin
    if (t_rise > 0 && ($realtime - t_rise) < min_gap) min_gap = $realtime - t_rise;
  end

  // ---- checking helpers ----
  function automatic logic [15:0] expw(int k);
    return {mem[(2 * k + 1) % 512], mem[(2 * k) % 512]};
  endfunction

  function automatic bit legal(int o, int c);
    return (o < SIZE) && (c != 0) && (c <= SIZE - o);
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  logic [15:0] got_w [SIZE];
  int got_n, cyc_done;
  bit got_eb, got_et, hung;

  task automatic do_read(int ofs, int cnt);
    int guard;
    got_n = 0; hung = 0; guard = 0;
    @(negedge clk);
    req = 1'b1; req_offset = 16'(ofs); req_count = 16'(cnt);
    @(negedge clk);
    req = 1'b0;
    forever begin
      if (word_valid && got_n < SIZE) begin got_w[got_n] = word_data; got_n++; end
      if (done) begin got_eb = err_bounds; got_et = err_timeout; cyc_done = guard; break; end
      if (guard > 40000) begin hung = 1; break; end
      @(negedge clk);
      guard++;
    end
    chk(!hung, "R10", "watchdog done", hung, 0);
  endtask

  task automatic good_read(int ofs, int cnt, string rq);
    int sr0, rc0;
    sr0 = stat_reads; rc0 = rd_cmds; min_gap = 1e9;
    do_read(ofs, cnt);
    chk(got_eb == 0 && got_et == 0, rq, "no error flags", {got_eb, got_et}, 0);
    chk(got_n == cnt, "R7", "word count", got_n, cnt);
    for (int i = 0; i < got_n && i < cnt; i++)
      chk(got_w[i] == expw(ofs + i), "R7", $sformatf("word %0d at ofs %0d", i, ofs),
          got_w[i], expw(ofs + i));
    chk(rd_cmds == rc0 + 1, "R6", "one read command", rd_cmds - rc0, 1);
    chk(last_op == ((ofs >= 128) ? 8'h0B : 8'h03), "R5", "read opcode", last_op,
        (ofs >= 128) ? 8'h0B : 8'h03);
    chk(stat_reads - sr0 >= 1, "R3", "status polled", stat_reads - sr0, 1);
    chk(min_gap >= 2 * HALF * CLK_P, "R8", "standby gap ns", int'(min_gap), 2 * HALF * CLK_P);
  endtask

  task automatic bad_read(int ofs, int cnt);
    int f0;
    f0 = cs_falls;
    do_read(ofs, cnt);
    chk(got_eb == 1 && got_et == 0, "R2", $sformatf("reject %0d/%0d", ofs, cnt),
        {got_eb, got_et}, 2);
    chk(cyc_done == 1, "R2", "reject done cycle", cyc_done, 1);
    chk(cs_falls == f0, "R2", "no chip select", cs_falls - f0, 0);
    chk(got_n == 0, "R2", "no words", got_n, 0);
  endtask

  initial begin
    int sr0, rc0, ofs, cnt, lim;
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    busy_left = 0; stat_reads = 0; rd_cmds = 0; cs_falls = 0; bcnt = 0;
    t_rise = 0; min_gap = 1e9; spi_miso = 1'b0; opc = 8'h00; last_op = 8'h00;
    req = 1'b0; req_offset = '0; req_count = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1 && spi_sck == 0 && busy == 0 && done == 0 && word_valid == 0,
        "R1", "reset state", {spi_cs_n, spi_sck, busy, done, word_valid}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_cs_n == 1 && busy == 0, "R1", "idle after reset", {spi_cs_n, busy}, 2'b10);
    cs_falls = 0;

    // directed corners
    good_read(0, 1, "R7");
    good_read(127, 2, "R5");   // crosses the 128-word boundary inside the burst
    good_read(200, 5, "R5");   // opcode folding
    good_read(255, 1, "R6");   // last word
    good_read(250, 6, "R2");   // exactly fits
    bad_read(0, 0);
    bad_read(256, 1);
    bad_read(250, 7);
    bad_read(16'hFFFF, 1);

    // busy device: three busy answers then ready
    busy_left = 3; sr0 = stat_reads;
    good_read(40, 3, "R3");
    chk(stat_reads - sr0 == 4, "R3", "status frames", stat_reads - sr0, 4);

    // device never ready
    busy_left = 1000000; sr0 = stat_reads; rc0 = rd_cmds;
    do_read(10, 4);
    chk(got_et == 1 && got_eb == 0, "R4", "timeout flag", {got_eb, got_et}, 1);
    chk(stat_reads - sr0 == PMAX, "R4", "poll attempts", stat_reads - sr0, PMAX);
    chk(rd_cmds == rc0, "R4", "no read command", rd_cmds - rc0, 0);
    chk(got_n == 0, "R4", "no words", got_n, 0);
    busy_left = 0;

    // constrained random
    for (int t = 0; t < 14; t++) begin
      ofs = $urandom % SIZE;
      lim = (SIZE - ofs < 24) ? SIZE - ofs : 24;
      cnt = 1 + ($urandom % lim);
      busy_left = $urandom % 3;
      if (legal(ofs, cnt)) good_read(ofs, cnt, "R9");
    end
    for (int t = 0; t < 4; t++) begin
      ofs = 200 + ($urandom % 100);
      cnt = (ofs < SIZE) ? SIZE - ofs + 1 + ($urandom % 4) : 1;
      bad_read(ofs, cnt);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule